// File: doc/BRIEF.md
# Fault Reset Sequencing Controller

This controller runs a processor's warm fault-reset sequence. The sequence starts when a single external request line goes high. On that edge the controller applies a selective reset to a few configuration registers and leaves others alone:

- the instruction-cache enable field is set to both caches on;
- the floating-point enable bit is set;
- the write-many chain register is cleared, which also turns the board cache off;
- the exception address captures the current PC;
- the fetch base register is left untouched.

The request line must then be released twice. After the first release a guard interval runs, and no self-test takes place. After the second release the controller goes through clock-forwarding setup. That setup is a capture window on the external framing clock, an alignment to its next rising edge plus a small margin, and a command guard. Each interval is counted in core clock cycles.

When the sequence completes, the controller returns to idle and issues a one-cycle fetch-start pulse. The fetch vector is the preserved base plus a fixed offset of 0x780. The framing clock is sampled in the core domain through a synchronizer, and only its rising edges are used. If the request line comes back high while a guard or capture interval is running, the sequence restarts from the fault-wait point.

Top module: `fault_reset_seq`

## Requirements
- R1: After power-on reset, `status` is 0, `busy` and `fetch_go` are low, and `icache_en`, `fp_enable`, `wmany_en` and `exc_addr` are all 0.
- R2: When `req` is high in idle (state code 0), the controller enters the fault-wait state (code 1) on the next clock edge and `busy` goes high.
- R3: On that same edge, `icache_en` becomes 2'b11, `fp_enable` becomes 1, `wmany_en` becomes 0, and `exc_addr` takes the value `pc` had in the cycle `req` was seen. Later changes to `pc` do not alter `exc_addr`.
- R4: A request pulse counts as held only once two synchronized rising edges of `frame_clk` have been seen while `req` is high; `status[3]` reports this. A release before that has no effect: the state code stays 1.
- R5: A held first release moves the controller to the first-guard state (code 2). It stays in code 2 at least GUARD_CYC cycles and, once the guard is over, until `req` rises again. That rise moves it to the second-arm state (code 3).
- R6: A held second release starts the capture state (code 4) for CAPTURE_CYC cycles. Next comes the align state (code 5), which lasts until the next synchronized rising edge of the framing clock. The margin state (code 6) then runs MARGIN_CYC cycles, and the command guard (code 7) runs GUARD_CYC cycles.
- R7: On return to idle, `fetch_go` is high for exactly one cycle. Counted from the edge on which the second release is taken, it comes CAPTURE_CYC + MARGIN_CYC + GUARD_CYC + 1 to that sum + 1 + one framing period cycles later.
- R8: `fetch_vec` always equals `base` + 0x780, truncated to ADDR_W bits.
- R9: `req` high during a running first guard, capture, align, margin or command guard returns the state to code 1 on the next edge. All interval counts restart from zero.
- R10: `busy` (also `status[4]`) is high from the edge that accepts the request until the edge that raises `fetch_go`, and it is low together with `fetch_go`. `status[7:5]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| req | input | 1 | Fault reset / clock-forward request line |
| frame_clk | input | 1 | External framing clock, asynchronous to `clk` |
| pc | input | ADDR_W | Current program counter |
| base | input | ADDR_W | Preserved fetch base register |
| icache_en | output | 2 | Instruction-cache enable field |
| fp_enable | output | 1 | Floating-point enable context bit |
| wmany_en | output | 1 | Write-many chain / board-cache enable |
| exc_addr | output | ADDR_W | Exception address register |
| status | output | 8 | {3'b0, busy, held, state code[2:0]} |
| busy | output | 1 | Sequence in progress |
| fetch_go | output | 1 | One-cycle fetch-start pulse |
| fetch_vec | output | ADDR_W | Fetch start address |

## Verification
The bench builds the controller with a capture window of 12 cycles, guards of 7 cycles and a 2-cycle margin. It runs the framing clock with a period of 8 core cycles. With these short intervals, every phase boundary can be reached within a few dozen cycles. As a result, several complete sequences, early releases and aborts in the middle of capture all fit in one short run. The align wait then varies over the whole framing period, and the latency window of R7 can be checked at both ends.

// File: rtl/frs_pkg.sv
package frs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FLT     = 3'd1,
    ST_GUARD1  = 3'd2,
    ST_ARM2    = 3'd3,
    ST_CAPTURE = 3'd4,
    ST_ALIGN   = 3'd5,
    ST_MARGIN  = 3'd6,
    ST_GUARD2  = 3'd7
  } frs_state_e;

  localparam int unsigned FRS_VEC_OFS = 32'h780;

  function automatic logic [63:0] frs_vector(input logic [63:0] b);
    return b + 64'(FRS_VEC_OFS);
  endfunction

  function automatic int unsigned frs_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/frs_frame_sync.sv
module frs_frame_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_in,
  output logic frame_rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], frame_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign frame_rise = sync_q[STAGES-1] & ~prev_q;

  assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> !frame_rise);

endmodule

// File: rtl/frs_guard_ctr.sv
module frs_guard_ctr #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = (cnt_q == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + W'(1);
  end

  assert_ctr_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && done && $stable(limit)) |=> done);

  assert_ctr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $stable(limit)) |=> (cnt_q < limit));

endmodule

// File: rtl/fault_reset_seq.sv
module fault_reset_seq
  import frs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CAPTURE_CYC = 525,
  parameter int unsigned GUARD_CYC   = 264,
  parameter int unsigned MARGIN_CYC  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              frame_clk,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] base,
  output logic [1:0]        icache_en,
  output logic              fp_enable,
  output logic              wmany_en,
  output logic [ADDR_W-1:0] exc_addr,
  output logic [7:0]        status,
  output logic              busy,
  output logic              fetch_go,
  output logic [ADDR_W-1:0] fetch_vec
);
  localparam int unsigned MAXC  = frs_max3(CAPTURE_CYC, GUARD_CYC, MARGIN_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  frs_state_e        state_q, state_d;
  logic              frame_rise;
  logic              ivl_done;
  logic              ivl_clr;
  logic [CNT_W-1:0]  ivl_limit;
  logic [1:0]        rises_q;
  logic              hold_ok;
  logic              load_cfg;
  logic              abort_seq;
  logic              seq_end;
  logic              fetch_go_q;

  frs_frame_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .frame_in(frame_clk), .frame_rise(frame_rise)
  );

  always_comb begin
    case (state_q)
      ST_GUARD1, ST_GUARD2: ivl_limit = CNT_W'(GUARD_CYC);
      ST_CAPTURE:           ivl_limit = CNT_W'(CAPTURE_CYC);
      ST_MARGIN:            ivl_limit = CNT_W'(MARGIN_CYC);
      default:              ivl_limit = CNT_W'(1);
    endcase
  end

  frs_guard_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(ivl_clr), .limit(ivl_limit), .done(ivl_done)
  );

  // held-request tracker: two synchronized framing rises = one full period
  assign hold_ok = (rises_q == 2'd2);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rises_q <= '0;
    else if (ivl_clr || !req) rises_q <= '0;
    else if ((state_q == ST_FLT || state_q == ST_ARM2) && frame_rise && !hold_ok)
      rises_q <= rises_q + 2'd1;
  end

  assign abort_seq = req && (state_q == ST_CAPTURE || state_q == ST_ALIGN ||
                             state_q == ST_MARGIN  || state_q == ST_GUARD2 ||
                             (state_q == ST_GUARD1 && !ivl_done));

  always_comb begin
    state_d = state_q;
    if (abort_seq) state_d = ST_FLT;
    else begin
      case (state_q)
        ST_IDLE:    if (req) state_d = ST_FLT;
        ST_FLT:     if (!req && hold_ok) state_d = ST_GUARD1;
        ST_GUARD1:  if (req) state_d = ST_ARM2;
        ST_ARM2:    if (!req && hold_ok) state_d = ST_CAPTURE;
        ST_CAPTURE: if (ivl_done) state_d = ST_ALIGN;
        ST_ALIGN:   if (frame_rise) state_d = ST_MARGIN;
        ST_MARGIN:  if (ivl_done) state_d = ST_GUARD2;
        ST_GUARD2:  if (ivl_done) state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  assign ivl_clr  = (state_d != state_q);
  assign load_cfg = (state_q == ST_IDLE) && req;
  assign seq_end  = (state_q == ST_GUARD2) && (state_d == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fetch_go_q <= 1'b0;
      icache_en  <= 2'b00;
      fp_enable  <= 1'b0;
      wmany_en   <= 1'b0;
      exc_addr   <= '0;
    end else begin
      state_q    <= state_d;
      fetch_go_q <= seq_end;
      if (load_cfg) begin
        icache_en <= 2'b11;
        fp_enable <= 1'b1;
        wmany_en  <= 1'b0;
        exc_addr  <= pc;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign fetch_go  = fetch_go_q;
  assign status    = {3'b000, busy, hold_ok, state_q};
  assign fetch_vec = ADDR_W'(frs_vector(64'(base)));

  assert_cfg_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (icache_en == 2'b11 && fp_enable && !wmany_en));

  assert_exc_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (exc_addr == $past(pc)));

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (state_q == ST_FLT));

  assert_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLT && !req && !hold_ok) |=> (state_q == ST_FLT));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req && state_q inside {ST_CAPTURE, ST_ALIGN, ST_MARGIN, ST_GUARD2})
      |=> (state_q == ST_FLT));

  assert_go_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> !busy);

  assert_go_from_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_go) |-> $past(busy));

endmodule

// File: tb/fault_reset_seq_tb.sv
module fault_reset_seq_tb;
  localparam int unsigned AW   = 32;
  localparam int unsigned CAP  = 12;
  localparam int unsigned GRD  = 7;
  localparam int unsigned MRG  = 2;
  localparam int unsigned FPER = 8;
  localparam int unsigned LAT_MIN = CAP + MRG + GRD + 1;
  localparam int unsigned LAT_MAX = LAT_MIN + FPER + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          frame_clk = 1'b0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] base = '0;
  logic [1:0]    icache_en;
  logic          fp_enable, wmany_en, busy, fetch_go;
  logic [AW-1:0] exc_addr, fetch_vec;
  logic [7:0]    status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_rel  = 0;
  bit done_run = 1'b0;

  typedef struct { logic [AW-1:0] vec; logic [AW-1:0] exc; } exp_t;
  exp_t sb_q[$];

  fault_reset_seq #(.ADDR_W(AW), .CAPTURE_CYC(CAP), .GUARD_CYC(GRD),
                    .MARGIN_CYC(MRG), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .frame_clk(frame_clk), .pc(pc),
    .base(base), .icache_en(icache_en), .fp_enable(fp_enable),
    .wmany_en(wmany_en), .exc_addr(exc_addr), .status(status), .busy(busy),
    .fetch_go(fetch_go), .fetch_vec(fetch_vec)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (FPER/2) @(negedge clk);
    #1 frame_clk = ~frame_clk;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // hold req long enough for two synchronized framing rises, then release
  task automatic held_pulse(input string tag, input logic [2:0] code);
    req = 1'b1;
    step(2 * FPER + 4);
    check({tag, " held status"}, status, {3'b000, 1'b1, 1'b1, code});
    req = 1'b0;
  endtask

  task automatic first_half(input logic [AW-1:0] b, input logic [AW-1:0] p);
    exp_t e;
    base = b; pc = p; req = 1'b1;
    e.vec = b + 32'h780; e.exc = p;
    sb_q.push_back(e);
    step(1);
    check("R2 enter fault wait", status[2:0], 3'd1);
    check("R3 seed regs", {icache_en, fp_enable, wmany_en}, 4'b1110);
    pc = ~p;
    step(1);
    check("R3 exc_addr latched", exc_addr, p);
    step(2 * FPER + 2);
    check("R4 held flag", status[3], 1'b1);
    req = 1'b0;
    step(1);
    check("R5 first guard", status, 8'h12);
    step(GRD + 3);
    check("R5 waits for reassert", status[2:0], 3'd2);
    req = 1'b1;
    step(1);
    check("R5 arm second", status[2:0], 3'd3);
  endtask

  task automatic second_release();
    req = 1'b1;
    step(2 * FPER + 4);
    check("R4 second held", status[3], 1'b1);
    req = 1'b0;
    t_rel = cyc;
    step(1);
    check("R6 capture", status[2:0], 3'd4);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) step(1);
    check("R10 busy dropped", busy, 1'b0);
    step(1);
    check("R7 pulse one cycle", fetch_go, 1'b0);
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && fetch_go) begin
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected fetch_go: actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R8 fetch_vec", fetch_vec, e.vec);
        check("R3 exc_addr at go", exc_addr, e.exc);
        check("R10 not busy at go", busy, 1'b0);
        if ((cyc - t_rel) < LAT_MIN || (cyc - t_rel) > LAT_MAX) begin
          fails++;
          $display("FAIL R7 latency: actual %0d expected %0d..%0d", cyc - t_rel,
                   LAT_MIN, LAT_MAX);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    check("R1 reset status", status, 8'h00);
    check("R1 reset outputs", {busy, fetch_go, icache_en, fp_enable, wmany_en}, 6'b0);
    check("R1 reset exc_addr", exc_addr, 0);

    // full sequence
    first_half(32'h1000_0000, 32'h0000_4321);
    second_release();
    wait_idle();
    check("R1 idle status", status, 8'h00);

    // early release ignored
    base = 32'hABCD_0000; pc = 32'h0000_0888; req = 1'b1;
    begin exp_t e; e.vec = 32'hABCD_0780; e.exc = 32'h0000_0888; sb_q.push_back(e); end
    step(3);
    req = 1'b0;
    step(2);
    check("R4 early release ignored", status[2:0], 3'd1);
    check("R10 busy held", busy, 1'b1);
    held_pulse("R4", 3'd1);
    step(1);
    check("R5 guard after held", status[2:0], 3'd2);
    step(GRD + 1);
    req = 1'b1;
    step(1);
    check("R5 arm", status[2:0], 3'd3);
    // abort during capture
    step(2 * FPER + 4);
    req = 1'b0;
    step(4);
    check("R6 in capture", status[2:0], 3'd4);
    req = 1'b1;
    step(1);
    check("R9 abort to fault wait", status[2:0], 3'd1);
    check("R9 hold cleared", status[3], 1'b0);
    step(2 * FPER + 4);
    req = 1'b0;
    step(1);
    check("R9 restart first guard", status[2:0], 3'd2);
    // reassert during first guard aborts
    step(2);
    req = 1'b1;
    step(1);
    check("R9 abort in first guard", status[2:0], 3'd1);
    step(2 * FPER + 4);
    req = 1'b0;
    step(GRD + 2);
    req = 1'b1;
    step(1);
    check("R5 arm after restart", status[2:0], 3'd3);
    second_release();
    step(CAP + 1);
    check("R6 align or later", status[2:0] >= 3'd5, 1'b1);
    wait_idle();

    // third sequence with a different framing phase
    step(3);
    first_half(32'hFFFF_F900, 32'h8000_0000);
    step(3);
    second_release();
    wait_idle();
    base = 32'h0000_1234;
    step(1);
    check("R8 vector combinational", fetch_vec, 32'h0000_19B4);

    check("R7 scoreboard drained", sb_q.size(), 0);
    done_run = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule